// File: doc/BRIEF.md
# Shared-Bus Ownership Semaphore

This block arbitrates ownership of one shared bus between a host and an embedded controller. The host sees one control register. Writing a 1 to the request bit asks for the bus. Reading the same bit back shows whether the host was granted it: 1 means the host owns the bus, and 0 means the host must try again. A separate write-one bit in the same register gives the bus back. The embedded controller uses a level handshake. It raises a request line, receives a grant, and releases the bus by dropping the request.

The host keeps ownership for a whole transfer, including any port-select change made for that transfer and its later restoration. A host request that arrives while the embedded controller owns the bus is dropped, not queued, and host software decides how long to keep retrying. The block drives a code that names the current owner.

Top module: `bus_sema_top`

## Requirements
- R1: After reset the owner code is 0 (free), `ec_gnt` is 0, `host_owns` is 0 and `host_rdata` is 0.
- R2: A host write with bit 4 set, made while the bus is free and `ec_req` is low, makes the host the owner on the next cycle. The owner code is then 1 and `host_rdata` bit 4 reads 1. A write with bit 4 clear requests nothing.
- R3: A host request made while the embedded controller owns the bus is not retained. Bit 4 reads 0, and once `ec_req` drops the bus becomes free, not host-owned.
- R4: A host write with bit 5 set, made while the host owns the bus, ends host ownership. This also holds when bit 4 is set in the same write. With `ec_req` low the bus becomes free.
- R5: `host_rdata` bit 5 and every bit other than bit 4 always read 0.
- R6: A bit 5 write made while the host is not the owner has no effect on ownership.
- R7: When the host request and `ec_req` arrive in the same cycle on a free bus, the embedded controller wins. The owner code becomes 2 and `ec_gnt` becomes 1.
- R8: While the host owns the bus, `ec_req` is not granted. If `ec_req` is high when the host releases, the bus passes directly to the embedded controller on the next cycle.
- R9: A host request made while the host already owns the bus leaves the ownership unchanged.
- R10: The embedded controller keeps the bus for as long as `ec_req` stays high and frees it on the cycle after `ec_req` drops. `ec_gnt` and `host_owns` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host write strobe for the control register |
| host_wdata | input | 8 | Host write data: bit 4 requests the bus, bit 5 releases it |
| host_rdata | output | 8 | Control register read value: bit 4 is 1 when the host owns the bus |
| ec_req | input | 1 | Embedded controller request, held high for the whole time it needs the bus |
| ec_gnt | output | 1 | Grant to the embedded controller |
| host_owns | output | 1 | The host currently owns the bus |
| bus_owner | output | 2 | Owner code: 0 free, 1 host, 2 embedded controller |

## Verification
Two pairs of events can fall in the same cycle. The first is a host request on a free bus together with a rising `ec_req`. The bench provokes it by driving both on the same clock and expects the embedded controller to win. The second is a host release while `ec_req` is already pending. The bench expects the bus to pass straight to the embedded controller on the next cycle, with no free cycle between the two owners. A behavioural model in the bench predicts the owner after every clock and compares it with the outputs in each cycle. This also covers writes that set the request and release bits together.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_EC   = 2'd2
  } owner_e;
endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/sema_host_port.sv
module sema_host_port #(
  parameter int REG_W   = 8,
  parameter int REQ_BIT = 4,
  parameter int REL_BIT = 5
) (
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             host_own,
  output logic             host_req,
  output logic             host_rel,
  output logic [REG_W-1:0] rdata
);
  logic unused_wbits;

  assign unused_wbits = ^wdata;
  assign host_req     = wr & wdata[REQ_BIT];
  assign host_rel     = wr & wdata[REL_BIT];

  always_comb begin
    rdata          = '0;
    rdata[REQ_BIT] = host_own;
  end
endmodule

// File: rtl/sema_arbiter.sv
module sema_arbiter
  import sema_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sn,
  input  logic   host_req,
  input  logic   host_rel,
  input  logic   ec_req,
  output owner_e owner
);
  owner_e st_q;
  owner_e st_d;
  logic   st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OWN_FREE: begin
        if (ec_req)        st_d = OWN_EC;
        else if (host_req) st_d = OWN_HOST;
      end
      OWN_HOST: begin
        if (host_rel) st_d = ec_req ? OWN_EC : OWN_FREE;
      end
      OWN_EC: begin
        if (!ec_req) st_d = OWN_FREE;
      end
      default: st_d = OWN_FREE;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    st_q <= OWN_FREE;
    else if (st_en) st_q <= st_d;
  end

  assign owner = st_q;

  AST_GRANT_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_FREE && host_req && !ec_req) |=> (owner == OWN_HOST)); // R2
  AST_EC_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_EC && ec_req) |=> (owner == OWN_EC)); // R3
  AST_REL_TO_FREE: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_HOST && host_rel && !ec_req) |=> (owner == OWN_FREE)); // R4
  AST_EC_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_FREE && host_req && ec_req) |=> (owner == OWN_EC)); // R7
  AST_HOST_KEEPS: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_HOST && !host_rel) |=> (owner == OWN_HOST)); // R8
  AST_EC_FREES: assert property (@(posedge clk) disable iff (!rst_sn)
    (owner == OWN_EC && !ec_req) |=> (owner == OWN_FREE)); // R10
endmodule

// File: rtl/bus_sema_top.sv
module bus_sema_top
  import sema_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int REQ_BIT     = 4,
  parameter int REL_BIT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             ec_req,
  output logic             ec_gnt,
  output logic             host_owns,
  output logic [1:0]       bus_owner
);
  logic   rst_sn;
  logic   host_req;
  logic   host_rel;
  owner_e owner;

  sema_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sema_host_port #(.REG_W(REG_W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_port (
    .wr       (host_wr),
    .wdata    (host_wdata),
    .host_own (host_owns),
    .host_req (host_req),
    .host_rel (host_rel),
    .rdata    (host_rdata)
  );

  sema_arbiter u_arb (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .host_req (host_req),
    .host_rel (host_rel),
    .ec_req   (ec_req),
    .owner    (owner)
  );

  assign host_owns = (owner == OWN_HOST);
  assign ec_gnt    = (owner == OWN_EC);
  assign bus_owner = owner;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({host_owns, ec_gnt})); // R10
  AST_REL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    host_rdata[REL_BIT] == 1'b0); // R5
endmodule

// File: tb/tb_bus_sema_top.sv
module tb_bus_sema_top;
  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       ec_req;
  logic       ec_gnt;
  logic       host_owns;
  logic [1:0] bus_owner;

  int tests;
  int fails;
  int model;

  bus_sema_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ec_req     (ec_req),
    .ec_gnt     (ec_gnt),
    .host_owns  (host_owns),
    .bus_owner  (bus_owner)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string tag);
    logic [7:0] exp_rd;
    exp_rd = (model == 1) ? 8'h10 : 8'h00;
    tests++;
    if (host_rdata !== exp_rd || bus_owner !== model[1:0] ||
        ec_gnt !== (model == 2) || host_owns !== (model == 1)) begin
      fails++;
      $display("FAIL %s: rdata=%h owner=%0d gnt=%b host=%b, expected rdata=%h owner=%0d",
               tag, host_rdata, bus_owner, ec_gnt, host_owns, exp_rd, model);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic e, input string tag);
    @(negedge clk);
    host_wr = w; host_wdata = d; ec_req = e;
    @(posedge clk);
    if (model == 0) begin
      if (e) model = 2;
      else if (w && d[4]) model = 1;
    end else if (model == 1) begin
      if (w && d[5]) model = e ? 2 : 0;
    end else begin
      if (!e) model = 0;
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; model = 0;
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = 8'h00; ec_req = 1'b0;
    repeat (3) @(posedge clk);
    #2; compare("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2; compare("R1 after reset");

    step(1'b1, 8'hEF, 1'b0, "R2 bit4 clear no request");
    step(1'b1, 8'h10, 1'b0, "R2 host grant");
    step(1'b1, 8'h10, 1'b0, "R9 rerequest while owner");
    step(1'b0, 8'h00, 1'b1, "R8 ec blocked");
    step(1'b0, 8'h00, 1'b1, "R8 ec still blocked");
    step(1'b1, 8'h20, 1'b1, "R8 handoff on release");
    step(1'b1, 8'h10, 1'b1, "R3 host request dropped");
    step(1'b1, 8'h20, 1'b1, "R6 release while ec owns");
    step(1'b1, 8'h10, 1'b0, "R3 request not retained");
    step(1'b0, 8'h00, 1'b0, "R10 ec freed");
    step(1'b1, 8'h20, 1'b0, "R6 release while free");
    step(1'b1, 8'hFF, 1'b0, "R5 readback of all-ones write");
    step(1'b1, 8'h30, 1'b0, "R4 release wins over request");
    step(1'b1, 8'h10, 1'b0, "R2 grant again");
    step(1'b1, 8'h20, 1'b0, "R4 release to free");
    step(1'b1, 8'h10, 1'b1, "R7 tie goes to ec");
    step(1'b0, 8'h00, 1'b1, "R10 ec holds");
    step(1'b0, 8'h00, 1'b0, "R10 ec drops");
    for (int i = 0; i < 40; i++) begin
      step(((i % 3) != 0), 8'((i * 37) ^ 8'h5A), ((i % 5) > 1), "R5 mixed pattern");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule